// File: doc/BRIEF.md
# Pipelined Byte-Write SRAM Datapath

A synchronous single-port memory for the data side of a pipelined static RAM. The word is split into byte lanes, and each lane holds eight data bits plus one parity bit. The address controller supplies a select strobe and a word address. Every selected cycle registers the address, the write data and the write controls together. A write commits to the lane arrays on the following clock edge.

A global write stores every lane. A byte write stores only the lanes picked by their active-low selects, and only while the byte-write enable is low. A selected cycle that is neither of these is a read. Read data is loaded into an output register one clock after the address was registered.

The pad is split into separate data-in, data-out and drive-enable ports. The drive enable is gated by the output-enable input without a clock. It stays low for the first read that follows a deselected cycle.

Top module: `sram_bytewr_dp`

## Requirements
- R1: While reset is high and after it is released, `rd_data` is all zeros and `drive_en` is low until a read result appears.
- R2: A selected cycle with `gw_n` low writes `wr_data` to every lane at `addr`, whatever `bwe_n` and `bsel_n` are.
- R3: With `gw_n` high and `bwe_n` low, lane i is written only when `bsel_n[i]` is low. Lanes with their select high keep their old contents.
- R4: A selected cycle with `gw_n` high is a read when `bwe_n` is high, or when `bwe_n` is low with every `bsel_n` bit high. It changes no stored bit.
- R5: The data of a read registered at clock edge N is on `rd_data` after edge N+1. When the read is not masked, `drive_en` is then high while `oe_n` is low.
- R6: `drive_en` is low whenever `oe_n` is high. It follows `oe_n` without waiting for a clock edge.
- R7: A read registered in the cycle right after a deselected cycle (`sel` low), or as the first access after reset, loads `rd_data` but leaves `drive_en` low for its output cycle.
- R8: The output cycle that follows a write has `drive_en` low.
- R9: A cycle with `sel` low writes nothing, and its output cycle has `drive_en` low.
- R10: A read registered in the cycle right after a write to the same address returns the newly written data.
- R11: Lane i occupies bits [9i+8:9i] of `wr_data` and `rd_data`. Bit 9i+8 is that lane's parity bit and is stored and returned like the data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Access strobe from the address controller, active high |
| addr | input | ADDR_W | Word address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| wr_data | input | 9*LANES | Write data, one 9-bit field per lane |
| rd_data | output | 9*LANES | Registered read data |
| drive_en | output | 1 | Pad drive enable for rd_data |

## Verification
A write commits to the arrays in the same clock edge that registers the next access. The bench therefore issues a write and, in the very next cycle, a read of the same address, and compares the word returned with the written value rather than the old contents. It also lets a masked read and an unmasked read land in consecutive output cycles. It then checks that `drive_en` stays low for the first and rises for the second while `rd_data` is correct in both.

// File: rtl/sram_dp_pkg.sv
package sram_dp_pkg;

  typedef struct packed {
    logic       par;
    logic [7:0] dat;
  } lane_t;

  localparam int LANE_W = $bits(lane_t);

endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage
  import sram_dp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bsel_n,
  input  logic [WORD_W-1:0] wr_data,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [WORD_W-1:0] s1_data,
  output logic [LANES-1:0]  lane_we,
  output logic              s1_rd,
  output logic              s1_first
);

  logic             s1_valid;
  logic             s1_gw_n;
  logic             s1_bwe_n;
  logic [LANES-1:0] s1_bsel_n;
  logic             s1_bytewr;

  // Access register: every control is captured together with its address
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_first  <= 1'b1;
      s1_gw_n   <= 1'b1;
      s1_bwe_n  <= 1'b1;
      s1_bsel_n <= '1;
      s1_addr   <= '0;
      s1_data   <= '0;
    end else begin
      s1_valid  <= sel;
      s1_first  <= ~s1_valid;
      s1_gw_n   <= gw_n;
      s1_bwe_n  <= bwe_n;
      s1_bsel_n <= bsel_n;
      s1_addr   <= addr;
      s1_data   <= wr_data;
    end
  end

  // A byte write counts only when at least one lane is selected
  assign s1_bytewr = ~s1_bwe_n & ~(&s1_bsel_n);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_we
      assign lane_we[i] = s1_valid & (~s1_gw_n | (~s1_bwe_n & ~s1_bsel_n[i]));
    end
  endgenerate

  assign s1_rd = s1_valid & s1_gw_n & ~s1_bytewr;

endmodule

// File: rtl/sram_lane_mem.sv
module sram_lane_mem
  import sram_dp_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  lane_t             wd,
  output lane_t             q
);

  lane_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wd;
    end
  end

  // Output register of the RAM, synchronously cleared
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (re) begin
      q <= mem[addr];
    end
  end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic s1_rd,
  input  logic s1_first,
  input  logic oe_n,
  output logic drive_en
);

  logic out_valid;
  logic out_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= 1'b1;
    end else begin
      out_valid <= s1_rd;
      out_mask  <= s1_first;
    end
  end

  assign drive_en = out_valid & ~out_mask & ~oe_n;

endmodule

// File: rtl/sram_bytewr_dp.sv
module sram_bytewr_dp
  import sram_dp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sel,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        gw_n,
  input  logic                        bwe_n,
  input  logic [LANES-1:0]            bsel_n,
  input  logic                        oe_n,
  input  logic [LANES*LANE_W-1:0]     wr_data,
  output logic [LANES*LANE_W-1:0]     rd_data,
  output logic                        drive_en
);

  localparam int WORD_W = LANES * LANE_W;

  logic [ADDR_W-1:0] s1_addr;
  logic [WORD_W-1:0] s1_data;
  logic [LANES-1:0]  lane_we;
  logic              s1_rd;
  logic              s1_first;

  sram_in_stage #(
    .ADDR_W(ADDR_W),
    .LANES (LANES)
  ) in_i (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .addr    (addr),
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bsel_n  (bsel_n),
    .wr_data (wr_data),
    .s1_addr (s1_addr),
    .s1_data (s1_data),
    .lane_we (lane_we),
    .s1_rd   (s1_rd),
    .s1_first(s1_first)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      lane_t lane_q;
      sram_lane_mem #(
        .ADDR_W(ADDR_W)
      ) mem_i (
        .clk (clk),
        .rst (rst),
        .we  (lane_we[i]),
        .re  (s1_rd),
        .addr(s1_addr),
        .wd  (s1_data[i*LANE_W +: LANE_W]),
        .q   (lane_q)
      );
      assign rd_data[i*LANE_W +: LANE_W] = lane_q;
    end
  endgenerate

  sram_out_stage out_i (
    .clk     (clk),
    .rst     (rst),
    .s1_rd   (s1_rd),
    .s1_first(s1_first),
    .oe_n    (oe_n),
    .drive_en(drive_en)
  );

endmodule

// File: rtl/sram_bytewr_dp_chk.sv
module sram_bytewr_dp_chk #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              gw_n,
  input logic              bwe_n,
  input logic [LANES-1:0]  bsel_n,
  input logic              oe_n,
  input logic [WORD_W-1:0] rd_data,
  input logic              drive_en
);

  logic is_wr;
  logic is_rd;
  assign is_wr = sel && (!gw_n || (!bwe_n && !(&bsel_n)));
  assign is_rd = sel && !is_wr;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !drive_en)); // R1

  AST_BACK2BACK_DRIVE: assert property (@(posedge clk) disable iff (rst)
    is_rd ##1 is_rd |=> ##1 (drive_en == !oe_n)); // R5

  always_comb begin
    AST_OE_GATES: assert (!(drive_en && oe_n)); // R6
  end

  AST_FIRST_MASKED: assert property (@(posedge clk) disable iff (rst)
    !sel ##1 is_rd |=> ##1 !drive_en); // R7

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    is_wr |=> ##1 !drive_en); // R8

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !sel |=> ##1 !drive_en); // R9

endmodule

bind sram_bytewr_dp sram_bytewr_dp_chk #(
  .ADDR_W(ADDR_W),
  .LANES (LANES),
  .WORD_W(LANES * sram_dp_pkg::LANE_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .sel     (sel),
  .gw_n    (gw_n),
  .bwe_n   (bwe_n),
  .bsel_n  (bsel_n),
  .oe_n    (oe_n),
  .rd_data (rd_data),
  .drive_en(drive_en)
);

// File: tb/sram_bytewr_dp_tb_top.sv
module sram_bytewr_dp_tb_top;

  localparam int AW = 8;
  localparam int LN = 2;
  localparam int W  = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          gw_n = 1'b1;
  logic          bwe_n = 1'b1;
  logic [LN-1:0] bsel_n = '1;
  logic          oe_n = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  rd_data;
  logic          drive_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  sram_bytewr_dp #(.ADDR_W(AW), .LANES(LN)) dut_i (
    .clk(clk), .rst(rst), .sel(sel), .addr(addr), .gw_n(gw_n),
    .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n), .wr_data(wr_data),
    .rd_data(rd_data), .drive_en(drive_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One access per clock: drive after the falling edge, return at the next one
  task automatic step(input logic s, input logic g, input logic b, input logic [LN-1:0] bs,
                      input logic [AW-1:0] a, input logic [W-1:0] d);
    sel = s; gw_n = g; bwe_n = b; bsel_n = bs; addr = a; wr_data = d;
    @(negedge clk);
  endtask

  task automatic idle();                                        step(0, 1, 1, '1, '0, '0); endtask
  task automatic rd(input logic [AW-1:0] a);                    step(1, 1, 1, '1, a, '0); endtask
  task automatic wr_all(input logic [AW-1:0] a, input logic [W-1:0] d); step(1, 0, 1, '1, a, d); endtask
  task automatic wr_byte(input logic [AW-1:0] a, input logic [LN-1:0] s, input logic [W-1:0] d);
    step(1, 1, 0, s, a, d);
  endtask

  task automatic t_reset();
    check("R1 rd_data in reset", rd_data, 0);
    check("R1 drive_en in reset", drive_en, 0);
    rst = 1'b0;
    idle();
    check("R1 rd_data after reset", rd_data, 0);
    check("R1 drive_en after reset", drive_en, 0);
  endtask

  task automatic t_global_then_read();
    wr_all(8'd5, 18'h2A5C3);
    rd(8'd5);               // right after the write, same address
    idle();
    check("R10 read after write", rd_data, 18'h2A5C3);
    check("R5 drive_en on read output", drive_en, 1);
    // global write ignores byte qualifiers
    step(1, 0, 0, 2'b10, 8'd6, 18'h15A3C);
    rd(8'd6);
    idle();
    check("R2 global write all lanes", rd_data, 18'h15A3C);
  endtask

  task automatic t_byte_lanes();
    logic [W-1:0] exp;
    wr_all(8'd9, 18'h3FFFF);
    wr_byte(8'd9, 2'b10, 18'h00000);     // lane 0 only
    exp = 18'h3FE00;
    rd(8'd9);
    idle();
    check("R3 lane0 byte write", rd_data, exp);
    wr_byte(8'd9, 2'b01, 18'h12345);     // lane 1 only
    exp = (exp & 18'h001FF) | (18'h12345 & 18'h3FE00);
    rd(8'd9);
    idle();
    check("R3 lane1 byte write", rd_data, exp);
    // parity bits sit at the top of each lane
    wr_all(8'd10, 18'h0);
    wr_byte(8'd10, 2'b10, 18'h3FFFF & 18'h00100);
    wr_byte(8'd10, 2'b01, 18'h20000);
    rd(8'd10);
    idle();
    check("R11 parity bits 8 and 17", rd_data, 18'h20100);
  endtask

  task automatic t_unqualified();
    wr_all(8'd20, 18'h0ABCD);
    step(1, 1, 0, 2'b11, 8'd20, 18'h3FFFF);  // qualifier low, no lane: read
    idle();
    check("R4 no-lane cycle reads", rd_data, 18'h0ABCD);
    check("R4 no-lane cycle drives", drive_en, 1);
    step(1, 1, 1, 2'b00, 8'd20, 18'h11111);  // selects without qualifier
    rd(8'd20);
    idle();
    check("R4 selects ignored", rd_data, 18'h0ABCD);
  endtask

  task automatic t_oe_gate();
    wr_all(8'd30, 18'h03C3C);
    oe_n = 1'b1;
    rd(8'd30);
    rd(8'd30);
    check("R6 oe high blocks drive", drive_en, 0);
    oe_n = 1'b0;
    #1;
    check("R6 oe low drives at once", drive_en, 1);
    idle();
  endtask

  task automatic t_first_masked();
    wr_all(8'd40, 18'h1F00F);
    idle();
    rd(8'd40);
    rd(8'd40);
    check("R7 masked read data", rd_data, 18'h1F00F);
    check("R7 first read not driven", drive_en, 0);
    idle();
    check("R7 second read driven", drive_en, 1);
  endtask

  task automatic t_write_quiet();
    rd(8'd40);
    rd(8'd40);
    wr_all(8'd41, 18'h2BEEF);
    check("R8 read before write driven", drive_en, 1);
    idle();
    check("R8 write cycle not driven", drive_en, 0);
  endtask

  task automatic t_deselect();
    wr_all(8'd50, 18'h12121);
    rd(8'd50);
    step(0, 0, 0, 2'b00, 8'd50, 18'h3FFFF);  // deselected write attempt
    check("R9 read before deselect", drive_en, 1);
    idle();
    check("R9 deselect not driven", drive_en, 0);
    rd(8'd50);
    idle();
    check("R9 no write when deselected", rd_data, 18'h12121);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_global_then_read();
    t_byte_lanes();
    t_unqualified();
    t_oe_gate();
    t_first_masked();
    t_write_quiet();
    t_deselect();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule